// File: doc/BRIEF.md
# Quad DAC serial command controller

This block is the digital front end of a four-channel, 16-bit DAC. A host shifts 32-bit command frames in over a three-wire serial link (active-low frame select, serial clock, data). Each finished frame is decoded into a command, a channel address and a 16-bit value. Each channel holds a staging (input) register and an output (DAC) register. The four output registers are the only outputs of the block, and they drive the converters.

Three things decide when an output register takes the staged value. The first is the hardware load pin (active low), which works either level-held (synchronous) or pulsed (asynchronous). The second is a per-channel software override mask, which makes a channel behave as if the load pin were held low. The third is a set of commands that force an update. A falling edge on the clear input sets every staging and output register to a programmable clear level, and it throws away any frame that is being shifted in at that moment.

All serial and control inputs are re-timed into the system clock domain, and their edges are found from the re-timed samples. Commands take effect one system clock after the frame has been recognised.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: A frame is 32 bits, sent MSB first and sampled on falling serial-clock edges while frame select is low. Bits 31:28 are ignored, the command is bits 27:24, the channel address is bits 23:20, the data is bits 19:4 and the auxiliary field is bits 3:0. A command executes only when the 32nd falling edge arrives.
- R2: If frame select rises before 32 bits have arrived, the frame is discarded with no effect.
- R3: Address 1111 selects all channels, and addresses 0000, 0001, 0010 and 0011 select channels A, B, C and D. Any other address selects nothing.
- R4: Command 0000 writes the addressed staging registers. An output register changes only when a load condition applies to its channel.
- R5: Command 0010 writes and loads the addressed channels. Command 0001 writes the addressed channels and loads all channels. Command 0011 loads the addressed channels from their staging registers. All three act whatever the level of the load pin.
- R6: If the re-timed load pin is low when a command 0000 completes, each written channel's output register takes the new value at the same time.
- R7: A falling edge on the load pin copies every staging register into its output register.
- R8: Command 0110 loads the software override mask from bits 3:0 (bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D). A channel whose bit is 1 loads on a write as though the pin were low. The mask resets to 0000.
- R9: Command 0101 sets the clear selection from bits 1:0: 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF, and 11 leaves the registers unchanged. The selection resets to 00. A falling clear edge applies it to all staging and output registers.
- R10: A falling clear edge during a frame discards that frame. The rest of its bits are ignored until frame select rises, and the next complete frame executes normally.
- R11: After reset, all output registers read 0x0000.
- R12: Command codes other than 0000, 0001, 0010, 0011, 0101 and 0110 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Hardware load pin, active low |
| clr_n | input | 1 | Clear input; acts on its falling edge |
| dac_out | output | N_CH*16 | Output registers; channel A in bits 15:0, then B, C and D |

## Verification
The bench builds the block with its default parameters: four channels and a two-stage re-timer. With four channels, every address in the decode table, the broadcast address and every bit of the override mask can be used. The serial clock runs at one sixth of the system clock, so each serial edge is seen cleanly after re-timing. This lets the bench place a clear pulse or a frame-select release at a chosen bit of a frame and check which staging and output values survive.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int FRAME_BITS = 32;
    localparam int KEEP_BITS  = 28;
    localparam int DATA_W     = 16;
    localparam int MAX_CH     = 4;

    typedef enum logic [3:0] {
        CMD_WR_IN      = 4'b0000,
        CMD_WR_UPD_ALL = 4'b0001,
        CMD_WR_UPD     = 4'b0010,
        CMD_UPD        = 4'b0011,
        CMD_SET_CLR    = 4'b0101,
        CMD_SET_SWLD   = 4'b0110
    } qdac_cmd_e;

    typedef enum logic [1:0] {
        CLR_ZERO = 2'b00,
        CLR_MID  = 2'b01,
        CLR_FULL = 2'b10,
        CLR_NONE = 2'b11
    } qdac_clr_e;

    typedef struct packed {
        logic [3:0]        cmd;
        logic [3:0]        addr;
        logic [DATA_W-1:0] data;
        logic [3:0]        aux;
    } qdac_frame_t;

    function automatic logic [DATA_W-1:0] clear_value(input qdac_clr_e sel);
        logic [DATA_W-1:0] v;
        case (sel)
            CLR_MID:  v = {1'b1, {(DATA_W-1){1'b0}}};
            CLR_FULL: v = {DATA_W{1'b1}};
            default:  v = '0;
        endcase
        return v;
    endfunction

    function automatic logic is_write(input logic [3:0] c);
        return (c == CMD_WR_IN) || (c == CMD_WR_UPD_ALL) || (c == CMD_WR_UPD);
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= RST_VAL;
        else     stage[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= RST_VAL;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import qdac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_n,
    input  logic        bit_in,
    input  logic        shift_edge,
    input  logic        abort,
    output logic        done,
    output qdac_frame_t frame
);
    localparam int CW = $clog2(FRAME_BITS + 1);

    logic [CW-1:0]        cnt;
    logic                 dead;
    logic [KEEP_BITS-1:0] shreg;
    logic [KEEP_BITS-1:0] shnext;

    assign shnext = {shreg[KEEP_BITS-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            dead  <= 1'b0;
            shreg <= '0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                cnt  <= '0;
                dead <= 1'b1;
            end else if (sel_n) begin
                cnt  <= '0;
                dead <= 1'b0;
            end else if (shift_edge && !dead && cnt < CW'(FRAME_BITS)) begin
                shreg <= shnext;
                cnt   <= cnt + 1'b1;
                if (cnt == CW'(FRAME_BITS - 1)) begin
                    done  <= 1'b1;
                    frame <= qdac_frame_t'(shnext);
                end
            end
        end
    end

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_sel_discard_R2: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> (cnt == '0) && !done);
    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        abort |=> (cnt == '0) && !done);
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_load,
    input  logic [DATA_W-1:0] clr_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dac_load,
    output logic [DATA_W-1:0] dac_q
);
    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] in_next;

    assign in_next = wr_en ? wr_data : in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            dac_q <= '0;
        end else if (clr_load) begin
            in_q  <= clr_val;
            dac_q <= clr_val;
        end else begin
            in_q <= in_next;
            if (dac_load) dac_q <= in_next;
        end
    end

    assert_clear_load_R9: assert property (@(posedge clk) disable iff (rst)
        clr_load |=> (dac_q == $past(clr_val)) && (in_q == $past(clr_val)));
    assert_copy_staged_R7: assert property (@(posedge clk) disable iff (rst)
        (dac_load && !wr_en && !clr_load) |=> dac_q == $past(in_q));
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!dac_load && !clr_load) |=> $stable(dac_q));
endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
    import qdac_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sync_n,
    input  logic                     sclk,
    input  logic                     din,
    input  logic                     ldac_n,
    input  logic                     clr_n,
    output logic [N_CH*DATA_W-1:0]   dac_out
);
    localparam int NSIG = 5;

    logic [NSIG-1:0] lvl;
    logic            sel_s, sclk_s, din_s, ldac_s, clr_s;
    logic            sclk_p, ldac_p, clr_p;
    logic            sclk_fall, ldac_fall, clr_fall;

    qdac_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({clr_n, ldac_n, din, sclk, sync_n}),
        .q       (lvl)
    );

    assign {clr_s, ldac_s, din_s, sclk_s, sel_s} = lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= 1'b1;
            ldac_p <= 1'b1;
            clr_p  <= 1'b1;
        end else begin
            sclk_p <= sclk_s;
            ldac_p <= ldac_s;
            clr_p  <= clr_s;
        end
    end

    assign sclk_fall = sclk_p & ~sclk_s;
    assign ldac_fall = ldac_p & ~ldac_s;
    assign clr_fall  = clr_p  & ~clr_s;

    logic        frame_done;
    qdac_frame_t fr;

    qdac_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .sel_n      (sel_s),
        .bit_in     (din_s),
        .shift_edge (sclk_fall),
        .abort      (clr_fall),
        .done       (frame_done),
        .frame      (fr)
    );

    qdac_clr_e       clr_code;
    logic [N_CH-1:0] sw_ld;
    logic            exec;
    logic            clr_load;
    logic            ld_pulse;
    logic [N_CH-1:0] addr_mask;
    logic [N_CH-1:0] wr_mask;
    logic [N_CH-1:0] upd_mask;
    logic [N_CH-1:0] eff_ld;
    logic [N_CH-1:0] dac_load;

    assign exec     = frame_done & ~clr_fall;
    assign clr_load = clr_fall & (clr_code != CLR_NONE);
    assign ld_pulse = ldac_fall & ~clr_fall;
    assign eff_ld   = {N_CH{~ldac_s}} | sw_ld;

    for (genvar i = 0; i < N_CH; i++) begin : g_addr
        assign addr_mask[i] = (fr.addr == 4'hF) || (fr.addr == 4'(i));
    end

    always_comb begin
        wr_mask  = '0;
        upd_mask = '0;
        if (exec) begin
            case (fr.cmd)
                CMD_WR_IN: wr_mask = addr_mask;
                CMD_WR_UPD_ALL: begin
                    wr_mask  = addr_mask;
                    upd_mask = '1;
                end
                CMD_WR_UPD: begin
                    wr_mask  = addr_mask;
                    upd_mask = addr_mask;
                end
                CMD_UPD: upd_mask = addr_mask;
                default: ;
            endcase
        end
    end

    assign dac_load = {N_CH{ld_pulse}} | upd_mask | (wr_mask & eff_ld);

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_code <= CLR_ZERO;
            sw_ld    <= '0;
        end else if (exec) begin
            if (fr.cmd == CMD_SET_CLR)  clr_code <= qdac_clr_e'(fr.aux[1:0]);
            if (fr.cmd == CMD_SET_SWLD) sw_ld    <= fr.aux[N_CH-1:0];
        end
    end

    logic [DATA_W-1:0] clr_val;
    assign clr_val = clear_value(clr_code);

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        qdac_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .clr_load (clr_load),
            .clr_val  (clr_val),
            .wr_en    (wr_mask[i]),
            .wr_data  (fr.data),
            .dac_load (dac_load[i]),
            .dac_q    (dac_out[i*DATA_W +: DATA_W])
        );
    end

    assert_clr_noop_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_fall && clr_code == CLR_NONE) |=> $stable(dac_out));
    assert_force_upd_R5: assert property (@(posedge clk) disable iff (rst)
        (exec && fr.cmd == CMD_WR_UPD && fr.addr == 4'h0)
        |=> dac_out[DATA_W-1:0] == $past(fr.data));
    assert_bad_cmd_R12: assert property (@(posedge clk) disable iff (rst)
        (exec && fr.cmd == 4'b0111 && !ldac_fall) |=> $stable(dac_out));
endmodule

// File: tb/qdac_serial_ctrl_bench.sv
module qdac_serial_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam int NCH        = 4;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_n = 1'b1, sclk = 1'b1, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic [NCH*16-1:0] dac_out;

    int tests = 0;
    int fails = 0;
    logic [15:0] m [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_serial_ctrl #(.N_CH(NCH), .SYNC_STAGES(2)) u_qdac_serial_ctrl (
        .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .din(din),
        .ldac_n(ldac_n), .clr_n(clr_n), .dac_out(dac_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (dac_out[i*16 +: 16] !== m[i]) begin
                bad = 1'b1;
                $display("FAIL %s ch%0d actual=%h expected=%h", req, i, dac_out[i*16 +: 16], m[i]);
            end
        end
        tests++;
        if (bad) fails++;
    endtask

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] a,
                                       input logic [15:0] d, input logic [3:0] x);
        return {4'h0, c, a, d, x};
    endfunction

    task automatic bits(input logic [31:0] w, input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            din  = w[31-i];
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
        end
        sclk = 1'b1;
    endtask

    task automatic begin_frame();
        sync_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic end_frame();
        wait_clk(HALF);
        sync_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic send(input logic [3:0] c, input logic [3:0] a,
                        input logic [15:0] d, input logic [3:0] x);
        begin_frame();
        bits(mk(c, a, d, x), 0, 32);
        end_frame();
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0; wait_clk(4); ldac_n = 1'b1; wait_clk(8);
    endtask

    task automatic pulse_clr();
        clr_n = 1'b0; wait_clk(4); clr_n = 1'b1; wait_clk(8);
    endtask

    task automatic set_all(input logic [15:0] v);
        for (int i = 0; i < NCH; i++) m[i] = v;
    endtask

    task automatic t_reset();
        set_all(16'h0000);
        check("R11 reset");
    endtask

    task automatic t_default_clear();
        send(4'b0010, 4'h0, 16'h7777, 4'h0);
        m[0] = 16'h7777; check("R5 write+load A");
        pulse_clr();
        set_all(16'h0000); check("R9 default clear to zero");
    endtask

    task automatic t_async();
        send(4'b0000, 4'h0, 16'h1234, 4'h0);
        check("R4 staged write leaves outputs");
        pulse_ldac();
        m[0] = 16'h1234; check("R7 load pulse copies staged");
    endtask

    task automatic t_force();
        send(4'b0010, 4'h1, 16'h5555, 4'h0);
        m[1] = 16'h5555; check("R5 write+load B");
        send(4'b0000, 4'hF, 16'h0F0F, 4'h0);
        check("R4 broadcast staged write");
        send(4'b0011, 4'h2, 16'h0000, 4'h0);
        m[2] = 16'h0F0F; check("R3 R5 load C only");
        send(4'b0001, 4'h3, 16'hABCD, 4'h0);
        m[0] = 16'h0F0F; m[1] = 16'h0F0F; m[3] = 16'hABCD;
        check("R5 write D load all");
    endtask

    task automatic t_ignored();
        send(4'b0010, 4'h5, 16'h9999, 4'h0);
        check("R3 unmapped address");
        send(4'b0111, 4'h0, 16'h9999, 4'h0);
        check("R12 unknown command");
        pulse_ldac();
        check("R12 R3 staged registers untouched");
    endtask

    task automatic t_sync_mode();
        ldac_n = 1'b0; wait_clk(8);
        send(4'b0000, 4'h0, 16'h1111, 4'h0);
        m[0] = 16'h1111; check("R6 pin low loads on write");
        ldac_n = 1'b1; wait_clk(8);
    endtask

    task automatic t_sw_ld();
        send(4'b0110, 4'h0, 16'h0000, 4'b0100);
        send(4'b0000, 4'hF, 16'h2222, 4'h0);
        m[2] = 16'h2222; check("R8 override channel C");
        send(4'b0110, 4'h0, 16'h0000, 4'b0000);
        send(4'b0000, 4'h3, 16'h3333, 4'h0);
        check("R8 override cleared");
    endtask

    task automatic t_sync_abort();
        begin_frame();
        bits(mk(4'b0010, 4'h0, 16'h6666, 4'h0), 0, 20);
        end_frame();
        check("R2 short frame discarded");
        send(4'b0011, 4'h0, 16'h0000, 4'h0);
        m[0] = 16'h2222; check("R2 staged A not overwritten");
    endtask

    task automatic t_clear_codes();
        send(4'b0101, 4'h0, 16'h0000, 4'b0001);
        pulse_clr();
        set_all(16'h8000); check("R9 clear to mid");
        send(4'b0011, 4'hF, 16'h0000, 4'h0);
        check("R9 staged registers cleared too");
        send(4'b0101, 4'h0, 16'h0000, 4'b0010);
        pulse_clr();
        set_all(16'hFFFF); check("R9 clear to full");
        send(4'b0101, 4'h0, 16'h0000, 4'b0011);
        send(4'b0010, 4'h0, 16'h3333, 4'h0);
        m[0] = 16'h3333;
        pulse_clr();
        check("R9 code 11 no change");
    endtask

    task automatic t_clr_abort();
        logic [31:0] w;
        send(4'b0101, 4'h0, 16'h0000, 4'b0001);
        w = mk(4'b0010, 4'h1, 16'h4444, 4'h0);
        begin_frame();
        bits(w, 0, 16);
        clr_n = 1'b0; wait_clk(4); clr_n = 1'b1; wait_clk(4);
        bits(w, 16, 32);
        end_frame();
        set_all(16'h8000); check("R10 interrupted frame dropped");
        send(4'b0010, 4'h1, 16'h4444, 4'h0);
        m[1] = 16'h4444; check("R10 R1 next frame executes");
    endtask

    initial begin
        wait_clk(WATCHDOG);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_default_clear();
        t_async();
        t_force();
        t_ignored();
        t_sync_mode();
        t_sw_ld();
        t_sync_abort();
        t_clear_codes();
        t_clr_abort();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule